// File: doc/BRIEF.md
# Staged-Write Serial EEPROM Command Controller

This block is the memory-command layer of a single-wire serial EEPROM. It sits above a bit-level transceiver and a device-selection layer. From those it receives whole command, address and data bytes, and it hands back read bytes on request. The storage is a synthesizable register file of `PAGES` pages of 32 bytes each. With the default of 16 pages the array is 512 bytes, addressed 000h to 1FFh. A 32-byte staging buffer sits in front of the array.

Writes never go straight into the array. The master first fills the staging buffer through a write-buffer command, then reads back the target address and a status byte. The status byte holds the last offset written, a partial-byte flag and an accepted flag. The data is committed only when the master echoes the two address bytes and the status byte exactly. The commit then runs a busy period of `COPY_CYCLES` clock cycles. A CRC-16 of the write transaction is returned inverted when the write reaches the end of the buffer.

The transceiver signals each bus reset with `sess_start`. It raises `sess_partial` with it when the bus reset cut a byte short. Every command begins after a session start.

Top module: `scratch_eeprom_ctrl`

## Requirements
- R1: The high target-address byte keeps only the bits that address the array; every bit above address 1FFh (default size) is stored as zero. The stored value is what the master reads back and what the authorization echo must match.
- R2: Command 0Fh takes a low and a high target-address byte, then data bytes. Data is stored into the buffer starting at offset TA[4:0]. Each stored byte sets the ending offset to its own offset, so a 2-byte write at 0026h gives a status byte of 07h. The status byte layout is: bits 4:0 ending offset, bit 5 partial flag, bit 6 always 0, bit 7 accepted flag.
- R3: Command AAh returns, in order, the low address byte, the high address byte and the status byte. It then returns buffer bytes from offset TA[4:0] through offset 1Fh, and FFh for every read after that.
- R4: A session start with `sess_partial` high, while data bytes of a 0Fh command are being taken, sets the partial flag. Every whole data byte clears it. Command 0Fh clears the accepted flag.
- R5: The CRC uses x^16+x^15+x^2+1, shifted LSB first from a cleared register, over the 0Fh byte, both address bytes and every stored data byte. Once offset 1Fh has been written, the next two reads return the CRC inverted, low byte first, and FFh follows. Reads during a data phase that has not reached 1Fh return FFh.
- R6: Command 55h followed by bytes equal to the low address, the high address and the status byte is accepted when the partial flag is clear and the ending offset is not below TA[4:0]. It sets the accepted flag and copies buffer offsets TA[4:0] through the ending offset to the same offsets of the target page. Every other array byte is left unchanged.
- R7: Command 55h with any echo byte differing is refused. `copy_busy` stays low, the array is unchanged, and every read returns FFh until the next session start.
- R8: An accepted copy holds `copy_busy` high for exactly `COPY_CYCLES` cycles. Every read from the echo onward returns AAh (alternating bits starting with 0, LSB first) until the next session start.
- R9: Command F0h loads the target address from two bytes and leaves the status byte unchanged. It then returns array bytes from that address up to the last address, and FFh after that.
- R10: An unrecognized command byte makes the block ignore all further bytes until the next session start, returning FFh for reads.
- R11: Each `rd_req` pulse produces `rd_valid` with the read byte on `rd_byte` exactly one cycle later. After reset, `rd_valid` and `copy_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_start | input | 1 | One-cycle pulse: bus reset seen, next byte is a command |
| sess_partial | input | 1 | With `sess_start`: the bus reset cut a byte short |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a byte from the master |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | One-cycle pulse: master wants the next byte |
| rd_valid | output | 1 | Read byte valid, one cycle after `rd_req` |
| rd_byte | output | 8 | Byte returned to the master |
| copy_busy | output | 1 | High while a commit to the array runs |

## Verification
The assertions assume the layer above never raises `rx_valid`, `rd_req` and `sess_start` in the same cycle. They also assume a new session is not started in the middle of a copy. The stimulus keeps to both. Each byte is driven alone for one cycle, and every copy is waited out before the next session. Random pages, offsets, lengths and occasionally corrupted echoes are mixed with directed cases: the offset-26h example, a write ending at 1Fh, the address masking, the array end and the unknown command.

// File: rtl/sep_pkg.sv
`timescale 1ns/1ps
package sep_pkg;

    localparam int SP_BYTES = 32;
    localparam int OFF_W    = 5;

    localparam logic [7:0] CMD_WRITE_SP = 8'h0F;
    localparam logic [7:0] CMD_READ_SP  = 8'hAA;
    localparam logic [7:0] CMD_COPY_SP  = 8'h55;
    localparam logic [7:0] CMD_READ_MEM = 8'hF0;

    localparam logic [7:0]  IDLE_BYTE = 8'hFF;
    localparam logic [7:0]  COPY_TONE = 8'hAA;
    localparam logic [15:0] CRC_POLY  = 16'hA001;

    typedef enum logic [3:0] {
        ST_CMD, ST_WTA1, ST_WTA2, ST_WDATA, ST_WCRC, ST_RSP,
        ST_CA1, ST_CA2, ST_CES, ST_COPY, ST_MTA1, ST_MTA2,
        ST_MREAD, ST_HALT
    } sep_state_e;

    typedef struct packed {
        logic             accepted;
        logic             zero;
        logic             partial;
        logic [OFF_W-1:0] end_off;
    } status_t;

    function automatic logic [15:0] crc16_step(input logic [15:0] crc,
                                               input logic [7:0]  data);
        logic [15:0] c;
        c = crc;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/sep_crc16.sv
`timescale 1ns/1ps
module sep_crc16 import sep_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst)      crc_q <= '0;
        else if (upd) crc_q <= crc16_step(clr ? 16'h0000 : crc_q, data);
    end

    assign crc = crc_q;
endmodule

// File: rtl/sep_byte_file.sv
`timescale 1ns/1ps
module sep_byte_file #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sep_copy_unit.sv
`timescale 1ns/1ps
module sep_copy_unit import sep_pkg::*; #(
    parameter int COPY_CYCLES = 250000,
    localparam int CW = $clog2(COPY_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OFF_W-1:0] span,
    output logic             busy,
    output logic [OFF_W-1:0] idx,
    output logic             we
);
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [OFF_W-1:0] span_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            span_q <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            span_q <= span;
        end else if (busy_q) begin
            if (cnt_q == CW'(COPY_CYCLES - 1)) busy_q <= 1'b0;
            else                               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy = busy_q;
    assign idx  = cnt_q[OFF_W-1:0];
    assign we   = busy_q && (cnt_q <= CW'(span_q));
endmodule

// File: rtl/scratch_eeprom_ctrl.sv
`timescale 1ns/1ps
module scratch_eeprom_ctrl import sep_pkg::*; #(
    parameter int PAGES       = 16,
    parameter int COPY_CYCLES = 250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sess_start,
    input  logic       sess_partial,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rd_req,
    output logic       rd_valid,
    output logic [7:0] rd_byte,
    output logic       copy_busy
);
    localparam int DEPTH = PAGES * SP_BYTES;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [7:0]  TA2_MASK = 8'((DEPTH - 1) >> 8);
    localparam logic [AW:0] MEM_END  = (AW+1)'(DEPTH);

    sep_state_e       state_q;
    logic [15:0]      ta_q;
    logic [OFF_W-1:0] end_q;
    logic             pf_q, aa_q, match_q;
    logic [OFF_W:0]   ptr_q;
    logic [1:0]       hdr_q;
    logic [AW:0]      maddr_q;
    logic             rd_valid_q;
    logic [7:0]       rd_byte_q;

    logic             rx_take, crc_clr, crc_upd, sp_we, auth_ok, copy_start;
    logic [15:0]      crc, ta_next;
    logic [7:0]       es_byte, sp_rdata, mem_rdata, rd_mux;
    logic [OFF_W-1:0] copy_idx, sp_raddr, copy_off, copy_span;
    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    status_t          status;

    assign status    = '{accepted: aa_q, zero: 1'b0, partial: pf_q, end_off: end_q};
    assign es_byte   = status;
    assign rx_take   = rx_valid && !sess_start;
    assign ta_next   = {rx_byte & TA2_MASK, ta_q[7:0]};
    assign copy_off  = ta_q[OFF_W-1:0];
    assign copy_span = end_q - copy_off;

    assign crc_clr = rx_take && state_q == ST_CMD && !copy_busy && rx_byte == CMD_WRITE_SP;
    assign crc_upd = crc_clr || (rx_take && (state_q == ST_WTA1 || state_q == ST_WTA2 ||
                                             state_q == ST_WDATA));
    assign sp_we   = rx_take && state_q == ST_WDATA;
    assign auth_ok = match_q && rx_byte == es_byte && !pf_q && end_q >= copy_off;
    assign copy_start = rx_take && state_q == ST_CES && auth_ok;

    sep_crc16 u_crc (
        .clk (clk), .rst (rst), .clr (crc_clr), .upd (crc_upd),
        .data(rx_byte), .crc (crc)
    );

    sep_copy_unit #(.COPY_CYCLES(COPY_CYCLES)) u_copy (
        .clk (clk), .rst (rst), .start(copy_start), .span(copy_span),
        .busy(copy_busy), .idx(copy_idx), .we(mem_we)
    );

    assign sp_raddr  = copy_busy ? OFF_W'(copy_off + copy_idx) : ptr_q[OFF_W-1:0];
    assign mem_waddr = {ta_q[AW-1:OFF_W], OFF_W'(copy_off + copy_idx)};

    sep_byte_file #(.DEPTH(SP_BYTES)) u_buf (
        .clk(clk), .we(sp_we), .waddr(ptr_q[OFF_W-1:0]), .wdata(rx_byte),
        .raddr(sp_raddr), .rdata(sp_rdata)
    );

    sep_byte_file #(.DEPTH(DEPTH)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(sp_rdata),
        .raddr(maddr_q[AW-1:0]), .rdata(mem_rdata)
    );

    // Byte the master sees on the next read slot group
    always_comb begin
        rd_mux = IDLE_BYTE;
        case (state_q)
            ST_RSP: begin
                case (hdr_q)
                    2'd0:    rd_mux = ta_q[7:0];
                    2'd1:    rd_mux = ta_q[15:8];
                    2'd2:    rd_mux = es_byte;
                    default: rd_mux = ptr_q[OFF_W] ? IDLE_BYTE : sp_rdata;
                endcase
            end
            ST_WCRC: begin
                case (hdr_q)
                    2'd0:    rd_mux = ~crc[7:0];
                    2'd1:    rd_mux = ~crc[15:8];
                    default: rd_mux = IDLE_BYTE;
                endcase
            end
            ST_MREAD: rd_mux = (maddr_q < MEM_END) ? mem_rdata : IDLE_BYTE;
            ST_CES:   rd_mux = IDLE_BYTE;
            ST_COPY:  rd_mux = COPY_TONE;
            default:  rd_mux = IDLE_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_CMD;
            ta_q       <= '0;
            end_q      <= '0;
            pf_q       <= 1'b0;
            aa_q       <= 1'b0;
            match_q    <= 1'b0;
            ptr_q      <= '0;
            hdr_q      <= '0;
            maddr_q    <= '0;
            rd_valid_q <= 1'b0;
            rd_byte_q  <= IDLE_BYTE;
        end else begin
            rd_valid_q <= rd_req;
            if (rd_req) rd_byte_q <= rd_mux;

            if (sess_start) begin
                if (sess_partial && state_q == ST_WDATA) pf_q <= 1'b1;
                state_q <= ST_CMD;
            end else if (rx_valid) begin
                case (state_q)
                    ST_CMD: begin
                        if (!copy_busy) begin
                            case (rx_byte)
                                CMD_WRITE_SP: begin
                                    aa_q    <= 1'b0;
                                    state_q <= ST_WTA1;
                                end
                                CMD_READ_SP: begin
                                    hdr_q   <= '0;
                                    ptr_q   <= {1'b0, copy_off};
                                    state_q <= ST_RSP;
                                end
                                CMD_COPY_SP: begin
                                    match_q <= 1'b1;
                                    state_q <= ST_CA1;
                                end
                                CMD_READ_MEM: state_q <= ST_MTA1;
                                default:      state_q <= ST_HALT;
                            endcase
                        end
                    end
                    ST_WTA1: begin
                        ta_q[7:0] <= rx_byte;
                        state_q   <= ST_WTA2;
                    end
                    ST_WTA2: begin
                        ta_q    <= ta_next;
                        ptr_q   <= {1'b0, copy_off};
                        state_q <= ST_WDATA;
                    end
                    ST_WDATA: begin
                        end_q <= ptr_q[OFF_W-1:0];
                        pf_q  <= 1'b0;
                        if (&ptr_q[OFF_W-1:0]) begin
                            hdr_q   <= '0;
                            state_q <= ST_WCRC;
                        end else begin
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                    ST_CA1: begin
                        match_q <= match_q && (rx_byte == ta_q[7:0]);
                        state_q <= ST_CA2;
                    end
                    ST_CA2: begin
                        match_q <= match_q && (rx_byte == ta_q[15:8]);
                        state_q <= ST_CES;
                    end
                    ST_CES: begin
                        if (auth_ok) begin
                            aa_q    <= 1'b1;
                            state_q <= ST_COPY;
                        end else begin
                            state_q <= ST_HALT;
                        end
                    end
                    ST_MTA1: begin
                        ta_q[7:0] <= rx_byte;
                        state_q   <= ST_MTA2;
                    end
                    ST_MTA2: begin
                        ta_q    <= ta_next;
                        maddr_q <= {1'b0, ta_next[AW-1:0]};
                        state_q <= ST_MREAD;
                    end
                    default: ;
                endcase
            end else if (rd_req) begin
                case (state_q)
                    ST_RSP: begin
                        if (hdr_q != 2'd3)      hdr_q <= hdr_q + 1'b1;
                        else if (!ptr_q[OFF_W]) ptr_q <= ptr_q + 1'b1;
                    end
                    ST_WCRC: if (hdr_q != 2'd2) hdr_q <= hdr_q + 1'b1;
                    ST_MREAD: if (maddr_q < MEM_END) maddr_q <= maddr_q + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_byte  = rd_byte_q;
endmodule

// File: rtl/sep_checker.sv
`timescale 1ns/1ps
module sep_checker import sep_pkg::*; #(
    parameter int PAGES       = 16,
    parameter int COPY_CYCLES = 250000
) (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        sess_start,
    input logic        rd_req,
    input logic        rd_valid,
    input logic [7:0]  rd_byte,
    input logic        copy_busy,
    input logic        mem_we,
    input sep_state_e  state,
    input logic [15:0] ta,
    input logic        pf,
    input logic        aa
);
    localparam int AW = $clog2(PAGES * SP_BYTES);

    int unsigned busy_len;
    always_ff @(posedge clk) begin
        if (rst)            busy_len <= 0;
        else if (copy_busy) busy_len <= busy_len + 1;
        else                busy_len <= 0;
    end

    p_ta_range_r1: assert property (@(posedge clk) disable iff (rst)
        (ta >> AW) == 16'd0);

    p_pf_cleared_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !sess_start && state == ST_WDATA) |=> !pf);

    p_aa_on_copy_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(copy_busy) |-> aa);

    p_write_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> copy_busy);

    p_refused_reads_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(state) == ST_HALT) |-> rd_byte == IDLE_BYTE);

    p_copy_tone_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(state) == ST_COPY) |-> rd_byte == COPY_TONE);

    p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(copy_busy) |-> busy_len == COPY_CYCLES);

    p_rd_handshake_r11: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
endmodule

bind scratch_eeprom_ctrl sep_checker #(.PAGES(PAGES), .COPY_CYCLES(COPY_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .sess_start(sess_start),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte),
    .copy_busy(copy_busy), .mem_we(mem_we), .state(state_q),
    .ta(ta_q), .pf(pf_q), .aa(aa_q)
);

// File: tb/scratch_eeprom_ctrl_test.sv
`timescale 1ns/1ps
module scratch_eeprom_ctrl_test;
    localparam int COPY = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sess_start = 1'b0, sess_partial = 1'b0;
    logic       rx_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rd_valid, copy_busy;
    logic [7:0] rd_byte;

    int checks = 0, fails = 0;
    logic done = 1'b0;

    logic [7:0]  ref_mem [512];
    logic [7:0]  ref_sp  [32];
    logic [15:0] m_ta = 16'h0000;
    logic [4:0]  m_end = 5'd0;
    logic        m_pf = 1'b0, m_aa = 1'b0;
    logic [15:0] m_crc = 16'h0000;
    logic [7:0]  got;
    int          seedv;

    scratch_eeprom_ctrl #(.PAGES(16), .COPY_CYCLES(COPY)) uut (
        .clk(clk), .rst(rst), .sess_start(sess_start), .sess_partial(sess_partial),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .copy_busy(copy_busy)
    );

    always #10 clk = ~clk;

    // Reflected x^16+x^15+x^2+1: after the shift, feedback lands on bits 15, 13 and 0
    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] n;
        logic fb;
        n = c;
        for (int i = 0; i < 8; i++) begin
            fb = n[0] ^ d[i];
            n  = {1'b0, n[15:1]};
            n[15] = fb;
            n[13] = n[13] ^ fb;
            n[0]  = n[0] ^ fb;
        end
        return n;
    endfunction

    function automatic logic [7:0] es_ref();
        return {m_aa, 1'b0, m_pf, m_end};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic session(input logic partial);
        sess_start = 1'b1; sess_partial = partial;
        @(negedge clk);
        sess_start = 1'b0; sess_partial = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic fetch(output logic [7:0] b);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        b = rd_byte;
    endtask

    task automatic expect_rd(input string req, input logic [7:0] exp);
        logic [7:0] b;
        fetch(b);
        check(req, {31'd0, rd_valid}, 32'd1);
        check(req, {24'd0, b}, {24'd0, exp});
    endtask

    task automatic write_sp(input logic [7:0] t1, input logic [7:0] t2, input int n);
        logic [7:0] d;
        int off;
        session(1'b0);
        send(8'h0F); m_crc = crc_ref(16'h0000, 8'h0F);
        send(t1);    m_crc = crc_ref(m_crc, t1);
        send(t2);    m_crc = crc_ref(m_crc, t2);
        m_ta = {7'd0, t2[0], t1};
        m_aa = 1'b0;
        off  = int'(t1[4:0]);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            if (off + i <= 31) begin
                ref_sp[off + i] = d;
                m_end = 5'(off + i);
                m_pf  = 1'b0;
                m_crc = crc_ref(m_crc, d);
            end
            send(d);
        end
    endtask

    task automatic read_sp_check(input string req);
        session(1'b0);
        send(8'hAA);
        expect_rd(req, m_ta[7:0]);
        expect_rd(req, m_ta[15:8]);
        expect_rd(req, es_ref());
        for (int i = int'(m_ta[4:0]); i < 32; i++) expect_rd(req, ref_sp[i]);
        expect_rd(req, 8'hFF);
    endtask

    task automatic copy_do(input logic [7:0] t1, input logic [7:0] t2,
                           input logic [7:0] es, input logic probe);
        logic ok;
        int n;
        ok = (t1 == m_ta[7:0]) && (t2 == m_ta[15:8]) && (es == es_ref()) &&
             !m_pf && (m_end >= m_ta[4:0]);
        session(1'b0);
        send(8'h55); send(t1); send(t2); send(es);
        if (ok) begin
            n = 0;
            if (probe) begin
                expect_rd("R8 tone while busy", 8'hAA);
                n = 1;
            end
            while (copy_busy) begin
                n++;
                @(negedge clk);
            end
            check("R8 busy length", n, COPY);
            expect_rd("R8 tone after copy", 8'hAA);
            for (int i = int'(m_ta[4:0]); i <= int'(m_end); i++)
                ref_mem[{m_ta[8:5], 5'(i)}] = ref_sp[i];
            m_aa = 1'b1;
        end else begin
            check("R7 no busy on refusal", {31'd0, copy_busy}, 32'd0);
            expect_rd("R7 refused reads idle", 8'hFF);
        end
    endtask

    task automatic read_mem_check(input string req, input logic [7:0] t1,
                                  input logic [7:0] t2, input int n);
        int a;
        session(1'b0);
        send(8'hF0); send(t1); send(t2);
        m_ta = {7'd0, t2[0], t1};
        a = int'(m_ta);
        for (int i = 0; i < n; i++) begin
            if (a + i < 512) expect_rd(req, ref_mem[a + i]);
            else             expect_rd(req, 8'hFF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d0, d1;
        int p, off, n;
        logic [7:0] es;
        seedv = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R11 reset copy_busy", {31'd0, copy_busy}, 32'd0);

        // Fill the whole array page by page (R2, R6)
        for (int pg = 0; pg < 16; pg++) begin
            write_sp(8'(pg * 32), 8'((pg * 32) >> 8), 32);
            copy_do(m_ta[7:0], m_ta[15:8], es_ref(), pg == 0);
        end
        read_mem_check("R9 full array", 8'h00, 8'h00, 514);

        // Two bytes at 0026h: header 26 00 07 (R2, R3)
        write_sp(8'h26, 8'h00, 2);
        session(1'b0);
        send(8'hAA);
        expect_rd("R2 ta1", 8'h26);
        expect_rd("R2 ta2", 8'h00);
        expect_rd("R2 status 07", 8'h07);
        read_sp_check("R3 scratch readback");
        copy_do(8'h26, 8'h00, 8'h07, 1'b1);
        read_sp_check("R6 accepted flag");
        read_mem_check("R6 page after copy", 8'h20, 8'h00, 32);

        // Refused copy: wrong status echo (R7), accepted flag cleared by write (R4)
        write_sp(8'h40, 8'h00, 1);
        expect_rd("R5 no crc before 1Fh", 8'hFF);
        read_sp_check("R4 accepted flag cleared");
        copy_do(8'h40, 8'h00, 8'h01, 1'b0);
        expect_rd("R7 still idle", 8'hFF);
        read_mem_check("R7 array unchanged", 8'h40, 8'h00, 32);

        // Partial byte at reset (R4)
        write_sp(8'h40, 8'h00, 2);
        session(1'b1);
        m_pf = 1'b1;
        read_sp_check("R4 partial flag");
        copy_do(8'h40, 8'h00, es_ref(), 1'b0);

        // CRC after ending offset 1Fh (R5)
        write_sp(8'h3C, 8'h00, 4);
        expect_rd("R5 crc low", ~m_crc[7:0]);
        expect_rd("R5 crc high", ~m_crc[15:8]);
        expect_rd("R5 after crc", 8'hFF);
        write_sp(8'hE0, 8'h01, 33);
        expect_rd("R5 crc low full", ~m_crc[7:0]);
        expect_rd("R5 crc high full", ~m_crc[15:8]);

        // Address masking (R1) and array end (R9)
        write_sp(8'h10, 8'hFF, 3);
        session(1'b0);
        send(8'hAA);
        expect_rd("R1 ta1", 8'h10);
        expect_rd("R1 ta2 masked", 8'h01);
        es = es_ref();
        read_mem_check("R9 array end", 8'hFE, 8'h03, 4);
        check("R1 masked ta", {16'd0, m_ta}, 32'h01FE);
        check("R9 status kept", {24'd0, es_ref()}, {24'd0, es});
        read_sp_check("R9 status unchanged");

        // Unknown command (R10)
        session(1'b0);
        send(8'h33); send(8'h0F); send(8'h00); send(8'h00); send(8'h12);
        expect_rd("R10 ignored", 8'hFF);
        read_sp_check("R10 state untouched");

        // Random traffic
        for (int it = 0; it < 25; it++) begin
            p   = int'($urandom % 16);
            off = int'($urandom % 32);
            n   = 1 + int'($urandom % (32 - off));
            write_sp(8'(p * 32 + off), 8'((p * 32) >> 8), n);
            read_sp_check("R3 random readback");
            es = es_ref();
            if ($urandom % 4 == 0) es = es ^ 8'h01;
            copy_do(m_ta[7:0], m_ta[15:8], es, 1'b0);
            read_mem_check("R6 random page", 8'(p * 32), 8'((p * 32) >> 8), 32);
        end

        d0 = 8'h00; d1 = 8'h00;
        fetch(d0);
        check("R11 rd_valid pulse", {31'd0, rd_valid}, 32'd1);
        @(negedge clk);
        d1 = {7'd0, rd_valid};
        check("R11 rd_valid single", {24'd0, d1}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule